// File: doc/BRIEF.md
# Operand Address Sequencer for an 8-bit Processor

This block works out where an instruction's operand lives for an 8-bit processor with a 16-bit address space. When an instruction is issued, it receives the addressing mode on a small select input. It then reads the operand bytes that follow the program counter through a byte-wide synchronous read port. Where the mode calls for it, it also reads a two-byte pointer from page zero. From these it forms the effective address. It reports how many bus cycles the instruction occupies and moves the program counter past the instruction when it finishes.

The execution stage places the opcode's addressing mode and the X and Y index values on the inputs and pulses `start`. A cycle counter is loaded with the instruction's cycle count when the instruction is accepted. The counter runs down to zero. `done` pulses for one cycle on the edge where it reaches zero, and the effective address, cycle count and updated program counter are valid at that point. A new instruction may be issued in the same cycle that `done` is high. Instruction execution and arithmetic are handled elsewhere.

Top module: `ea_sequencer`

## Requirements
- R1: After reset, `pc` equals the `RESET_PC` parameter. `done`, `memRd`, `effAddr` and `cycles` are all zero.
- R2: The `mode` encoding is 0 implied, 1 immediate, 2 zero page, 3 zero page + X, 4 absolute, 5 absolute + Y, 6 pointer at (zero page + X), and 7 pointer at zero page then + Y. `done` is a one-cycle pulse that rises exactly N clock edges after the edge that accepted `start`. `cycles` then shows N. With no page crossing, N is 2, 2, 3, 4, 4, 4, 6 and 5 for modes 0 to 7.
- R3: `pc` changes only on the edge that raises `done`. It advances by 1 for implied, by 2 for immediate and the four page-zero-based modes (2, 3, 6, 7), and by 3 for modes 4 and 5.
- R4: Immediate mode gives `effAddr` = pc + 1. Implied mode gives `effAddr` = 0.
- R5: Zero page mode gives {0x00, operand}. Zero page + X gives {0x00, (operand + X) mod 256}, so operand 0x80 with X = 0xFF gives 0x007F.
- R6: Absolute modes read the low byte at pc + 1 and the high byte at pc + 2. Mode 5 adds Y over the full 16 bits, so 0x10FF + 1 = 0x1100.
- R7: Mode 6 forms the pointer (operand + X) mod 256. It reads the low address byte at the pointer and the high byte at (pointer + 1) mod 256, so the location after 0xFF is 0x00.
- R8: Mode 7 reads a 16-bit base at the operand and at (operand + 1) mod 256, low byte first, and adds Y. Base 0x1028 with Y = 0x10 gives 0x1038.
- R9: When adding Y carries into the high byte, mode 5 takes 5 cycles and mode 7 takes 6 cycles. No other mode ever adds a cycle.
- R10: `start` is ignored while an instruction is in progress. It is accepted on the cycle that `done` is high.
- R11: X and Y are sampled on the accepting edge. Later changes to `xIdx` or `yIdx` do not affect the result.
- R12: `memRd` is high for exactly one cycle per byte read: 0 for modes 0 and 1, 1 for modes 2 and 3, 2 for modes 4 and 5, and 3 for modes 6 and 7. Read data returns one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe for a new instruction |
| mode | input | 3 | Addressing mode select (encoding in R2) |
| xIdx | input | 8 | X index value |
| yIdx | input | 8 | Y index value |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read request |
| memRdata | input | 8 | Read data, one cycle after request |
| effAddr | output | 16 | Effective address |
| done | output | 1 | Instruction finished pulse |
| cycles | output | 3 | Bus cycles of the current instruction |
| pc | output | 16 | Program counter |

## Verification
The hardest case to reach is the one where the extra page-crossing cycle coincides with pointer reads that wrap in page zero. The carry into the high byte only appears after two or three dependent memory reads, and the wrap only appears when the operand or operand + X lands on 0xFF. The bench therefore places pointer bytes at 0xFF and 0x00 and chooses pointer bases such as 0x10FF, so that adding Y carries. It also issues a second `start` partway through a long instruction and scrambles X and Y after acceptance, to show that neither changes the count or the address.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

  typedef enum logic [2:0] {
    M_IMPL = 3'd0,
    M_IMM  = 3'd1,
    M_ZP   = 3'd2,
    M_ZPX  = 3'd3,
    M_ABS  = 3'd4,
    M_ABSY = 3'd5,
    M_IZX  = 3'd6,
    M_IZY  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    MS_PC1,
    MS_PC2,
    MS_ZPTR,
    MS_ZPTR1
  } memSel_e;

  typedef enum logic [1:0] {
    EA_NONE,
    EA_IMM,
    EA_ZP,
    EA_FULL
  } eaSrc_e;

  typedef struct packed {
    logic    accept;
    logic    memRd;
    memSel_e memSel;
    logic    capPtr;
    logic    capLo;
    logic    eaLoad;
    eaSrc_e  eaSrc;
    logic    idxX;
    logic    idxY;
    logic    pcAdv;
    logic [1:0] pcInc;
  } strobe_t;

  localparam int MAX_CYCLES = 6;

  function automatic int baseCycles(amode_e m);
    case (m)
      M_IMPL, M_IMM:         return 2;
      M_ZP:                  return 3;
      M_ZPX, M_ABS, M_ABSY:  return 4;
      M_IZY:                 return 5;
      default:               return 6;
    endcase
  endfunction

  function automatic logic [1:0] instrLen(amode_e m);
    case (m)
      M_IMPL:        return 2'd1;
      M_ABS, M_ABSY: return 2'd3;
      default:       return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/ea_seq_ctrl.sv
module ea_seq_ctrl
  import ea_seq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       modeIn,
  input  logic             pageCross,
  output strobe_t          st,
  output logic             done,
  output logic [CNT_W-1:0] cycles
);

  typedef enum logic [2:0] {S_IDLE, S_OP, S_B2, S_B3, S_B4, S_WAIT} state_e;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  state_e           state, nxt;
  amode_e           modeReg, modeNew;
  logic [CNT_W-1:0] cnt;
  logic             crossHit;

  assign modeNew  = amode_e'(modeIn);
  assign crossHit = st.eaLoad && (st.eaSrc == EA_FULL) && pageCross;

  always_comb begin
    st  = '0;
    nxt = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          st.accept = 1'b1;
          case (modeNew)
            M_IMPL: begin
              st.eaLoad = 1'b1;
              st.eaSrc  = EA_NONE;
              nxt       = S_WAIT;
            end
            M_IMM: begin
              st.eaLoad = 1'b1;
              st.eaSrc  = EA_IMM;
              nxt       = S_WAIT;
            end
            default: nxt = S_OP;
          endcase
        end
      end
      S_OP: begin
        st.memRd  = 1'b1;
        st.memSel = MS_PC1;
        nxt       = S_B2;
      end
      S_B2: begin
        case (modeReg)
          M_ZP: begin
            st.eaLoad = 1'b1;
            st.eaSrc  = EA_ZP;
            nxt       = S_WAIT;
          end
          M_ZPX: begin
            st.eaLoad = 1'b1;
            st.eaSrc  = EA_ZP;
            st.idxX   = 1'b1;
            nxt       = S_WAIT;
          end
          M_ABS, M_ABSY: begin
            st.capLo  = 1'b1;
            st.memRd  = 1'b1;
            st.memSel = MS_PC2;
            nxt       = S_B3;
          end
          M_IZX: begin
            st.capPtr = 1'b1;
            st.idxX   = 1'b1;
            st.memRd  = 1'b1;
            st.memSel = MS_ZPTR;
            nxt       = S_B3;
          end
          M_IZY: begin
            st.capPtr = 1'b1;
            st.memRd  = 1'b1;
            st.memSel = MS_ZPTR;
            nxt       = S_B3;
          end
          default: nxt = S_WAIT;
        endcase
      end
      S_B3: begin
        case (modeReg)
          M_ABS, M_ABSY: begin
            st.eaLoad = 1'b1;
            st.eaSrc  = EA_FULL;
            st.idxY   = (modeReg == M_ABSY);
            nxt       = S_WAIT;
          end
          default: begin
            st.capLo  = 1'b1;
            st.memRd  = 1'b1;
            st.memSel = MS_ZPTR1;
            nxt       = S_B4;
          end
        endcase
      end
      S_B4: begin
        st.eaLoad = 1'b1;
        st.eaSrc  = EA_FULL;
        st.idxY   = (modeReg == M_IZY);
        nxt       = S_WAIT;
      end
      S_WAIT: begin
        if (cnt == CNT_ONE) begin
          st.pcAdv = 1'b1;
          st.pcInc = instrLen(modeReg);
          nxt      = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      modeReg <= M_IMPL;
      cnt     <= '0;
      cycles  <= '0;
      done    <= 1'b0;
    end else begin
      state <= nxt;
      done  <= st.pcAdv;
      if (st.accept) begin
        modeReg <= modeNew;
        cnt     <= CNT_W'(baseCycles(modeNew));
        cycles  <= CNT_W'(baseCycles(modeNew));
      end else if (crossHit) begin
        cycles  <= cycles + CNT_ONE;
      end else if (cnt != '0) begin
        cnt     <= cnt - CNT_ONE;
      end
    end
  end

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a finished instruction never reports outside 2..6 cycles
  p_cycles_range_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles >= CNT_W'(2) && cycles <= CNT_W'(MAX_CYCLES)));

  // R10: an issue strobe during an instruction leaves the latched mode alone
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && start) |=> $stable(modeReg));

  // R12: reads are only requested while an instruction is in flight
  p_read_busy_r12: assert property (@(posedge clk) disable iff (rst)
    st.memRd |-> (state != S_IDLE));

endmodule

// File: rtl/ea_seq_dpath.sv
module ea_seq_dpath
  import ea_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RESET_PC = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               st,
  input  logic [DATA_W-1:0]     xIn,
  input  logic [DATA_W-1:0]     yIn,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0]   effAddr,
  output logic [2*DATA_W-1:0]   pc,
  output logic                  pageCross
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ZERO_PAGE = '0;
  localparam logic [DATA_W-1:0] BYTE_ONE  = DATA_W'(1);

  logic [DATA_W-1:0] xReg, yReg, ptrReg, loReg;
  logic [DATA_W-1:0] zpLow, idxVal, ptrNext;
  logic [ADDR_W-1:0] fullSum, pcPlus1, pcPlus2;

  assign idxVal  = st.idxX ? xReg : (st.idxY ? yReg : '0);
  assign zpLow   = memRdata + (st.idxX ? xReg : '0);
  assign ptrNext = ptrReg + BYTE_ONE;
  assign fullSum = {memRdata, loReg} + {ZERO_PAGE, idxVal};
  assign pcPlus1 = pc + ADDR_W'(1);
  assign pcPlus2 = pc + ADDR_W'(2);

  assign pageCross = st.idxY && (fullSum[ADDR_W-1:DATA_W] != memRdata);

  always_comb begin
    case (st.memSel)
      MS_PC1:   memAddr = pcPlus1;
      MS_PC2:   memAddr = pcPlus2;
      MS_ZPTR:  memAddr = {ZERO_PAGE, zpLow};
      default:  memAddr = {ZERO_PAGE, ptrNext};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg    <= '0;
      yReg    <= '0;
      ptrReg  <= '0;
      loReg   <= '0;
      effAddr <= '0;
      pc      <= ADDR_W'(RESET_PC);
    end else begin
      if (st.accept) begin
        xReg <= xIn;
        yReg <= yIn;
      end
      if (st.capPtr) ptrReg <= zpLow;
      if (st.capLo)  loReg  <= memRdata;
      if (st.eaLoad) begin
        case (st.eaSrc)
          EA_NONE: effAddr <= '0;
          EA_IMM:  effAddr <= pcPlus1;
          EA_ZP:   effAddr <= {ZERO_PAGE, zpLow};
          default: effAddr <= fullSum;
        endcase
      end
      if (st.pcAdv) pc <= pc + ADDR_W'(st.pcInc);
    end
  end

  // R3: program counter moves only on the completion edge
  p_pc_at_done_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> $past(st.pcAdv));

  // R5: page-zero results never leave page zero
  p_zp_page_r5: assert property (@(posedge clk) disable iff (rst)
    (st.eaLoad && st.eaSrc == EA_ZP) |=> (effAddr[ADDR_W-1:DATA_W] == '0));

  // R11: index copies hold between acceptances
  p_idx_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !st.accept |=> ($stable(xReg) && $stable(yReg)));

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 3,
  parameter int RESET_PC = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          mode,
  input  logic [DATA_W-1:0]   xIdx,
  input  logic [DATA_W-1:0]   yIdx,
  output logic [2*DATA_W-1:0] memAddr,
  output logic                memRd,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [2*DATA_W-1:0] effAddr,
  output logic                done,
  output logic [CNT_W-1:0]    cycles,
  output logic [2*DATA_W-1:0] pc
);

  strobe_t st;
  logic    pageCross;

  assign memRd = st.memRd;

  ea_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .modeIn    (mode),
    .pageCross (pageCross),
    .st        (st),
    .done      (done),
    .cycles    (cycles)
  );

  ea_seq_dpath #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .xIn       (xIdx),
    .yIn       (yIdx),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .effAddr   (effAddr),
    .pc        (pc),
    .pageCross (pageCross)
  );

endmodule

// File: tb/ea_sequencer_bench.sv
`timescale 1ns/1ps
module ea_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  mode;
  logic [7:0]  xIdx, yIdx;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memRdata;
  logic [15:0] effAddr;
  logic        done;
  logic [2:0]  cycles;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  logic [15:0] pcExp;
  logic [7:0]  mem [logic [15:0]];

  always #2.5 clk = ~clk;

  ea_sequencer #(.RESET_PC(16'h0400)) u_ea_sequencer (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .xIdx(xIdx), .yIdx(yIdx),
    .memAddr(memAddr), .memRd(memRd), .memRdata(memRdata), .effAddr(effAddr),
    .done(done), .cycles(cycles), .pc(pc)
  );

  function automatic logic [7:0] peek(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) if (memRd) memRdata <= peek(memAddr);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Issues one instruction at the current negedge and checks its results.
  task automatic runInstr(input logic [2:0] m, input logic [7:0] xi, input logic [7:0] yi,
                          input int pokeAt, input bit scramble,
                          input logic [15:0] expEa, input string eaTag,
                          input int expCyc, input string cycTag,
                          input int len, input int expReads);
    int  n = 0;
    int  reads = 0;
    bit  seen = 0;
    start = 1'b1; mode = m; xIdx = xi; yIdx = yi;
    @(negedge clk);
    while (!seen && n < 40) begin
      if (n == 0) start = 1'b0;
      if (pokeAt > 0 && n == pokeAt) begin start = 1'b1; mode = 3'd1; end
      if (pokeAt > 0 && n == pokeAt + 1) start = 1'b0;
      if (scramble && n == 1) begin xIdx = ~xi; yIdx = ~yi; end
      if (memRd) reads++;
      @(negedge clk);
      n++;
      if (done) seen = 1;
    end
    start = 1'b0;
    chk(cycTag, "done edge count", n, expCyc);
    chk(cycTag, "cycles output", int'(cycles), expCyc);
    chk(eaTag, "effAddr", int'(effAddr), int'(expEa));
    chk("R3", "pc", int'(pc), int'(pcExp + 16'(len)));
    chk("R12", "reads", reads, expReads);
    pcExp = pcExp + 16'(len);
  endtask

  task automatic testReset();
    chk("R1", "pc", int'(pc), 16'h0400);
    chk("R1", "done", int'(done), 0);
    chk("R1", "memRd", int'(memRd), 0);
    chk("R1", "effAddr", int'(effAddr), 0);
    chk("R1", "cycles", int'(cycles), 0);
  endtask

  task automatic testImpliedImm();
    runInstr(3'd0, 8'h00, 8'h00, 0, 0, 16'h0000, "R4", 2, "R2", 1, 0);
    runInstr(3'd1, 8'h00, 8'h00, 0, 0, pcExp + 16'd1, "R4", 2, "R2", 2, 0);
  endtask

  task automatic testZeroPage();
    mem[pcExp + 16'd1] = 8'h20;
    runInstr(3'd2, 8'h00, 8'h00, 0, 0, 16'h0020, "R5", 3, "R2", 2, 1);
    mem[pcExp + 16'd1] = 8'h80;
    runInstr(3'd3, 8'hFF, 8'h00, 0, 0, 16'h007F, "R5", 4, "R2", 2, 1);
  endtask

  task automatic testAbsolute();
    mem[pcExp + 16'd1] = 8'hFF; mem[pcExp + 16'd2] = 8'h10;
    runInstr(3'd4, 8'h33, 8'h44, 0, 0, 16'h10FF, "R6", 4, "R2", 3, 2);
    mem[pcExp + 16'd1] = 8'h00; mem[pcExp + 16'd2] = 8'h10;
    runInstr(3'd5, 8'h00, 8'h01, 0, 0, 16'h1001, "R6", 4, "R2", 3, 2);
    mem[pcExp + 16'd1] = 8'hFF; mem[pcExp + 16'd2] = 8'h10;
    runInstr(3'd5, 8'h00, 8'h01, 0, 0, 16'h1100, "R6", 5, "R9", 3, 2);
  endtask

  task automatic testIndexedIndirect();
    mem[16'h0024] = 8'h74; mem[16'h0025] = 8'h20;
    mem[pcExp + 16'd1] = 8'h20;
    runInstr(3'd6, 8'h04, 8'h00, 0, 0, 16'h2074, "R7", 6, "R2", 2, 3);
    mem[16'h00FF] = 8'h34; mem[16'h0000] = 8'h12;
    mem[pcExp + 16'd1] = 8'hFB;
    runInstr(3'd6, 8'h04, 8'hF0, 0, 0, 16'h1234, "R7", 6, "R9", 2, 3);
  endtask

  task automatic testIndirectIndexed();
    mem[16'h0010] = 8'h28; mem[16'h0011] = 8'h10;
    mem[pcExp + 16'd1] = 8'h10;
    runInstr(3'd7, 8'h00, 8'h10, 0, 0, 16'h1038, "R8", 5, "R2", 2, 3);
    mem[16'h0030] = 8'hFF; mem[16'h0031] = 8'h10;
    mem[pcExp + 16'd1] = 8'h30;
    runInstr(3'd7, 8'h00, 8'h10, 0, 0, 16'h110F, "R8", 6, "R9", 2, 3);
    mem[pcExp + 16'd1] = 8'hFF;
    runInstr(3'd7, 8'h00, 8'h05, 0, 0, 16'h1239, "R8", 5, "R2", 2, 3);
  endtask

  task automatic testBusyStart();
    mem[pcExp + 16'd1] = 8'h20;
    runInstr(3'd6, 8'h04, 8'h00, 2, 0, 16'h2074, "R10", 6, "R10", 2, 3);
    // back-to-back issue right on the done cycle
    runInstr(3'd1, 8'h00, 8'h00, 0, 0, pcExp + 16'd1, "R10", 2, "R10", 2, 0);
  endtask

  task automatic testIndexSample();
    mem[pcExp + 16'd1] = 8'h80;
    runInstr(3'd3, 8'hFF, 8'h00, 0, 1, 16'h007F, "R11", 4, "R2", 2, 1);
    mem[pcExp + 16'd1] = 8'h10;
    runInstr(3'd7, 8'h00, 8'h10, 0, 1, 16'h1038, "R11", 5, "R11", 2, 3);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; mode = 3'd0; xIdx = '0; yIdx = '0;
    pcExp = 16'h0400;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testImpliedImm();
    testZeroPage();
    testAbsolute();
    testIndexedIndirect();
    testIndirectIndexed();
    testBusyStart();
    testIndexSample();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule